// File: doc/BRIEF.md
# Credit-Returning Latency Link for Cycle-Accurate Models

This block joins a producer and a consumer inside a cycle-accurate performance model. A model cycle spans one or more clock cycles. In each model cycle the producer closes its side exactly once. It does this either with an enqueue, which carries a message that may be valid or may be a bubble, or with a pass, which sends nothing. The consumer closes its side exactly once with a done, which hands back a number of credits. Before it closes, the consumer may pop the message that is on offer.

The message travels forward through a stage of `DATA_LAT` model cycles, and the credit count travels backward through a stage of `CRED_LAT` model cycles. Each latency is 0 or 1. The link stores only these stages and keeps no message queue, so the consumer keeps whatever buffer it needs. Setting both latencies to 1 gives a stall link: a stall downstream never reaches the producer through combinational logic. Setting data to 1 and credits to 0 models an ordinary pipeline register.

Each side runs a two-state machine. `SIDE_OPEN` waits for the closing action, and the close transition moves it to `SIDE_CLOSED`. When both sides are closed, or close on the same clock, the advance transition returns both machines to `SIDE_OPEN`. On that same clock the latency stages load and the model-cycle counter steps.

Top module: `credit_lat_port`

## Requirements
- R1: After reset, `prod_credits` equals `INIT_CREDITS`, `model_cycle` is 0, `cons_can_recv` is 0 and `prod_can_send` is 1.
- R2: `prod_can_send` is high only while the producer side is open and the credit count is nonzero. An enqueue with `prod_enq_valid`=1 lowers the count by one on that clock, and the count never exceeds `INIT_CREDITS`.
- R3: A pass, or an enqueue with `prod_enq_valid`=0, closes the producer side without spending a credit. The bubble it sends never raises `cons_can_recv`.
- R4: `model_cycle` increments by one on exactly the clock on which both sides are closed. This holds when the producer closes first, when the consumer closes first, and when both close on the same clock.
- R5: With `DATA_LAT`=1, a valid message enqueued in model cycle n is offered in model cycle n+1. While it is offered, `cons_can_recv` is 1 and `cons_data` equals the enqueued data, until the consumer pops or closes.
- R6: With `DATA_LAT`=0, a valid message is offered in the same model cycle. `cons_can_recv` and `cons_data` follow the enqueue inputs combinationally on the enqueue clock.
- R7: The count given with done in model cycle n is added to `prod_credits` on the advance clock that ends model cycle n+`CRED_LAT`.
- R8: Once the producer side has closed, `prod_can_send` stays 0 until the next advance. A second enqueue or pass in one model cycle is illegal.
- R9: A valid message that is not popped before the consumer closes is discarded. The next model cycle offers only the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_enq | input | 1 | Producer enqueue; closes the producer side |
| prod_enq_valid | input | 1 | 1 = message carries data, 0 = bubble |
| prod_enq_data | input | DATA_W | Message payload |
| prod_pass | input | 1 | Producer closes its side without sending |
| prod_can_send | output | 1 | Producer side open and a credit is held |
| prod_credits | output | CRED_W | Credits currently held by the producer |
| cons_can_recv | output | 1 | A valid, unpopped message is on offer |
| cons_data | output | DATA_W | Payload of the offered message |
| cons_pop | input | 1 | Consumer takes the offered message |
| cons_done | input | 1 | Consumer closes its side |
| cons_done_cred | input | CRED_W | Credits returned with done |
| model_cycle | output | CYC_W | Count of completed model cycles |

## Verification
The bench builds a main instance as a stall link with `DATA_LAT`=1, `CRED_LAT`=1 and `INIT_CREDITS`=3. This setting lets credits run out, which turns requested sends into bubbles. It also exposes the two-model-cycle credit turnaround, and a behavioural reference follows it through producer-first, consumer-first and same-clock closing orders. A second instance with both latencies 0 and a single credit brings the combinational forward path and the same-cycle credit return within reach.

// File: rtl/clp_pkg.sv
package clp_pkg;

    typedef enum logic {
        SIDE_OPEN   = 1'b0,
        SIDE_CLOSED = 1'b1
    } side_state_e;

endpackage

// File: rtl/clp_lat_stage.sv
module clp_lat_stage #(
    parameter int LAT = 1,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (LAT == 0) begin : g_through
            assign q = d;
        end else begin : g_reg
            logic [W-1:0] stage_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else if (adv) begin
                    stage_q <= d;
                end
            end

            assign q = stage_q;
        end
    endgenerate

endmodule

// File: rtl/clp_prod_side.sv
module clp_prod_side
    import clp_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int INIT_CREDITS = 4,
    parameter int CRED_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq,
    input  logic              enq_valid,
    input  logic [DATA_W-1:0] enq_data,
    input  logic              pass,
    input  logic              advance,
    input  logic [CRED_W-1:0] cred_in,
    output logic              can_send,
    output logic [CRED_W-1:0] credits,
    output logic              fin,
    output logic              closed,
    output logic              cur_valid,
    output logic [DATA_W-1:0] cur_data
);

    side_state_e       state_q, state_nx;
    logic              held_v;
    logic [DATA_W-1:0] held_d;
    logic              closing;
    logic              sent;
    logic [CRED_W:0]   cred_sum;

    assign closing = (state_q == SIDE_OPEN) && (enq || pass);
    assign sent    = (state_q == SIDE_OPEN) && enq && enq_valid;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SIDE_OPEN: begin
                if (advance) begin
                    state_nx = SIDE_OPEN;          // close and advance together
                end else if (enq || pass) begin
                    state_nx = SIDE_CLOSED;        // close
                end
            end
            SIDE_CLOSED: begin
                if (advance) begin
                    state_nx = SIDE_OPEN;          // advance
                end
            end
            default: state_nx = SIDE_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SIDE_OPEN;
        end else begin
            state_q <= state_nx;
        end
    end

    // message held from the close until the advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v <= 1'b0;
            held_d <= '0;
        end else if (closing) begin
            held_v <= enq && enq_valid;
            held_d <= enq_data;
        end
    end

    // credit counter
    always_comb begin
        cred_sum = {1'b0, credits}
                 + (advance ? {1'b0, cred_in} : '0)
                 - (CRED_W + 1)'(sent);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credits <= CRED_W'(INIT_CREDITS);
        end else begin
            credits <= cred_sum[CRED_W-1:0];
        end
    end

    // outputs
    always_comb begin
        can_send  = 1'b0;
        fin       = 1'b0;
        closed    = 1'b0;
        cur_valid = 1'b0;
        cur_data  = enq_data;
        unique case (state_q)
            SIDE_OPEN: begin
                can_send  = (credits != '0);
                fin       = enq || pass;
                cur_valid = enq && enq_valid;
                cur_data  = enq_data;
            end
            SIDE_CLOSED: begin
                fin       = 1'b1;
                closed    = 1'b1;
                cur_valid = held_v;
                cur_data  = held_d;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/clp_cons_side.sv
module clp_cons_side
    import clp_pkg::*;
#(
    parameter int CRED_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              done,
    input  logic [CRED_W-1:0] done_cred,
    input  logic              advance,
    input  logic              vis_valid,
    output logic              can_recv,
    output logic              fin,
    output logic [CRED_W-1:0] cur_cred
);

    side_state_e       state_q, state_nx;
    logic              popped_q;
    logic [CRED_W-1:0] held_cred;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SIDE_OPEN: begin
                if (advance) begin
                    state_nx = SIDE_OPEN;          // close and advance together
                end else if (done) begin
                    state_nx = SIDE_CLOSED;        // close
                end
            end
            SIDE_CLOSED: begin
                if (advance) begin
                    state_nx = SIDE_OPEN;          // advance
                end
            end
            default: state_nx = SIDE_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SIDE_OPEN;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            popped_q  <= 1'b0;
            held_cred <= '0;
        end else begin
            if (advance) begin
                popped_q <= 1'b0;
            end else if (can_recv && pop) begin
                popped_q <= 1'b1;
            end
            if ((state_q == SIDE_OPEN) && done) begin
                held_cred <= done_cred;
            end
        end
    end

    // outputs
    always_comb begin
        can_recv = 1'b0;
        fin      = 1'b0;
        cur_cred = '0;
        unique case (state_q)
            SIDE_OPEN: begin
                can_recv = vis_valid && !popped_q;
                fin      = done;
                cur_cred = done ? done_cred : '0;
            end
            SIDE_CLOSED: begin
                fin      = 1'b1;
                cur_cred = held_cred;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/credit_lat_port.sv
module credit_lat_port #(
    parameter int DATA_W       = 8,
    parameter int INIT_CREDITS = 4,
    parameter int DATA_LAT     = 1,
    parameter int CRED_LAT     = 1,
    parameter int CYC_W        = 16,
    localparam int CRED_W      = $clog2(INIT_CREDITS + 1),
    localparam int MSG_W       = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_enq,
    input  logic              prod_enq_valid,
    input  logic [DATA_W-1:0] prod_enq_data,
    input  logic              prod_pass,
    output logic              prod_can_send,
    output logic [CRED_W-1:0] prod_credits,
    output logic              cons_can_recv,
    output logic [DATA_W-1:0] cons_data,
    input  logic              cons_pop,
    input  logic              cons_done,
    input  logic [CRED_W-1:0] cons_done_cred,
    output logic [CYC_W-1:0]  model_cycle
);

    logic              p_fin;
    logic              c_fin;
    logic              p_closed;
    logic              advance;
    logic              p_cur_valid;
    logic [DATA_W-1:0] p_cur_data;
    logic [MSG_W-1:0]  fwd_msg;
    logic [CRED_W-1:0] c_cur_cred;
    logic [CRED_W-1:0] back_cred;
    logic [CYC_W-1:0]  cyc_q;

    assign advance = p_fin && c_fin;

    clp_prod_side #(
        .DATA_W       (DATA_W),
        .INIT_CREDITS (INIT_CREDITS),
        .CRED_W       (CRED_W)
    ) u_prod (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq       (prod_enq),
        .enq_valid (prod_enq_valid),
        .enq_data  (prod_enq_data),
        .pass      (prod_pass),
        .advance   (advance),
        .cred_in   (back_cred),
        .can_send  (prod_can_send),
        .credits   (prod_credits),
        .fin       (p_fin),
        .closed    (p_closed),
        .cur_valid (p_cur_valid),
        .cur_data  (p_cur_data)
    );

    clp_lat_stage #(
        .LAT (DATA_LAT),
        .W   (MSG_W)
    ) u_fwd_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (advance),
        .d     ({p_cur_valid, p_cur_data}),
        .q     (fwd_msg)
    );

    clp_cons_side #(
        .CRED_W (CRED_W)
    ) u_cons (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (cons_pop),
        .done      (cons_done),
        .done_cred (cons_done_cred),
        .advance   (advance),
        .vis_valid (fwd_msg[MSG_W-1]),
        .can_recv  (cons_can_recv),
        .fin       (c_fin),
        .cur_cred  (c_cur_cred)
    );

    clp_lat_stage #(
        .LAT (CRED_LAT),
        .W   (CRED_W)
    ) u_back_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (advance),
        .d     (c_cur_cred),
        .q     (back_cred)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (advance) begin
            cyc_q <= cyc_q + CYC_W'(1);
        end
    end

    assign cons_data   = fwd_msg[DATA_W-1:0];
    assign model_cycle = cyc_q;

endmodule

// File: rtl/clp_checker.sv
module clp_checker #(
    parameter int INIT_CREDITS = 4,
    parameter int CRED_W       = 3,
    parameter int CYC_W        = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prod_enq,
    input logic              prod_enq_valid,
    input logic              prod_pass,
    input logic [CRED_W-1:0] prod_credits,
    input logic              cons_pop,
    input logic              cons_can_recv,
    input logic [CYC_W-1:0]  model_cycle,
    input logic              p_fin,
    input logic              c_fin,
    input logic              p_closed
);

    a_r2_enq_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_closed && prod_enq && prod_enq_valid) |-> (prod_credits != '0));

    a_r2_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(prod_credits) <= INIT_CREDITS);

    a_r3_pass_keeps_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_closed && prod_pass && !c_fin) |=> (prod_credits == $past(prod_credits)));

    a_r4_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_fin && c_fin) |=> $stable(model_cycle));

    a_r4_step_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (p_fin && c_fin) |=> (model_cycle == $past(model_cycle) + CYC_W'(1)));

    a_r5_pop_offered: assert property (@(posedge clk) disable iff (!rst_n)
        cons_pop |-> cons_can_recv);

    a_r8_single_close: assert property (@(posedge clk) disable iff (!rst_n)
        p_closed |-> !(prod_enq || prod_pass));

endmodule

bind credit_lat_port clp_checker #(
    .INIT_CREDITS (INIT_CREDITS),
    .CRED_W       (CRED_W),
    .CYC_W        (CYC_W)
) u_clp_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .prod_enq       (prod_enq),
    .prod_enq_valid (prod_enq_valid),
    .prod_pass      (prod_pass),
    .prod_credits   (prod_credits),
    .cons_pop       (cons_pop),
    .cons_can_recv  (cons_can_recv),
    .model_cycle    (model_cycle),
    .p_fin          (p_fin),
    .c_fin          (c_fin),
    .p_closed       (p_closed)
);

// File: tb/test_credit_lat_port.sv
module test_credit_lat_port;

    localparam int DW   = 8;
    localparam int INIT = 3;
    localparam int CW   = $clog2(INIT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // main instance: stall link
    logic          prod_enq = 0, prod_enq_valid = 0, prod_pass = 0;
    logic [DW-1:0] prod_enq_data = '0;
    logic          prod_can_send, cons_can_recv;
    logic [CW-1:0] prod_credits;
    logic [DW-1:0] cons_data;
    logic          cons_pop = 0, cons_done = 0;
    logic [CW-1:0] cons_done_cred = '0;
    logic [15:0]   model_cycle;

    credit_lat_port #(
        .DATA_W(DW), .INIT_CREDITS(INIT), .DATA_LAT(1), .CRED_LAT(1), .CYC_W(16)
    ) i_credit_lat_port (
        .clk(clk), .rst_n(rst_n),
        .prod_enq(prod_enq), .prod_enq_valid(prod_enq_valid),
        .prod_enq_data(prod_enq_data), .prod_pass(prod_pass),
        .prod_can_send(prod_can_send), .prod_credits(prod_credits),
        .cons_can_recv(cons_can_recv), .cons_data(cons_data),
        .cons_pop(cons_pop), .cons_done(cons_done),
        .cons_done_cred(cons_done_cred), .model_cycle(model_cycle)
    );

    // second instance: zero latency both ways, one credit
    logic          q_enq = 0, q_valid = 0, q_pass = 0;
    logic [DW-1:0] q_din = '0;
    logic          q_can_send, q_can_recv;
    logic [0:0]    q_credits;
    logic [DW-1:0] q_dout;
    logic          q_pop = 0, q_done = 0;
    logic [0:0]    q_cred = '0;
    logic [15:0]   q_cyc;

    credit_lat_port #(
        .DATA_W(DW), .INIT_CREDITS(1), .DATA_LAT(0), .CRED_LAT(0), .CYC_W(16)
    ) i_credit_lat_port_zero (
        .clk(clk), .rst_n(rst_n),
        .prod_enq(q_enq), .prod_enq_valid(q_valid),
        .prod_enq_data(q_din), .prod_pass(q_pass),
        .prod_can_send(q_can_send), .prod_credits(q_credits),
        .cons_can_recv(q_can_recv), .cons_data(q_dout),
        .cons_pop(q_pop), .cons_done(q_done),
        .cons_done_cred(q_cred), .model_cycle(q_cyc)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference of the main instance, in model-cycle terms
    int      r_cred = INIT;
    int      r_cyc  = 0;
    int      r_owed = 0;
    int      r_pend = 0;
    bit      r_prev_v = 0;
    int      r_prev_d = 0;

    // kind: 0 pass, 1 bubble, 2 valid send; phase: 0 producer first,
    // 1 same clock, 2 consumer first
    task automatic mcycle(input int kind, input int d, input bit pop,
                          input int cred, input int phase);
        bit v;
        bit do_pop;
        int ret;
        check("R4 model_cycle at start", int'(model_cycle), r_cyc);
        check("R2 credits at start", int'(prod_credits), r_cred);
        check("R2 can_send at start", int'(prod_can_send), (r_cred > 0) ? 1 : 0);
        check("R5 can_recv at start", int'(cons_can_recv), int'(r_prev_v));
        if (r_prev_v) check("R5 cons_data", int'(cons_data), r_prev_d);
        v      = (kind == 2) && (r_cred > 0);
        do_pop = pop && r_prev_v;
        ret    = r_owed + (do_pop ? 1 : 0);
        if (cred < ret) ret = cred;
        if (phase == 0) begin
            prod_enq = (kind != 0); prod_enq_valid = v; prod_pass = (kind == 0);
            prod_enq_data = DW'(d);
            @(negedge clk);
            prod_enq = 0; prod_enq_valid = 0; prod_pass = 0;
            check("R2 R3 credits after producer close", int'(prod_credits),
                  r_cred - (v ? 1 : 0));
            check("R8 can_send low when closed", int'(prod_can_send), 0);
            check("R4 no advance on one side", int'(model_cycle), r_cyc);
            cons_pop = do_pop; cons_done = 1; cons_done_cred = CW'(ret);
            @(negedge clk);
            cons_pop = 0; cons_done = 0; cons_done_cred = '0;
        end else if (phase == 1) begin
            prod_enq = (kind != 0); prod_enq_valid = v; prod_pass = (kind == 0);
            prod_enq_data = DW'(d);
            cons_pop = do_pop; cons_done = 1; cons_done_cred = CW'(ret);
            @(negedge clk);
            prod_enq = 0; prod_enq_valid = 0; prod_pass = 0;
            cons_pop = 0; cons_done = 0; cons_done_cred = '0;
        end else begin
            cons_pop = do_pop; cons_done = 1; cons_done_cred = CW'(ret);
            @(negedge clk);
            cons_pop = 0; cons_done = 0; cons_done_cred = '0;
            check("R4 no advance on consumer close", int'(model_cycle), r_cyc);
            check("R5 can_recv low after consumer close", int'(cons_can_recv), 0);
            prod_enq = (kind != 0); prod_enq_valid = v; prod_pass = (kind == 0);
            prod_enq_data = DW'(d);
            @(negedge clk);
            prod_enq = 0; prod_enq_valid = 0; prod_pass = 0;
        end
        r_owed   = r_owed + (do_pop ? 1 : 0) - ret;
        r_cred   = r_cred - (v ? 1 : 0) + r_pend;   // R7: one model cycle late
        r_pend   = ret;
        r_prev_v = v;
        r_prev_d = d;
        r_cyc++;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 credits", int'(prod_credits), INIT);
        check("R1 model_cycle", int'(model_cycle), 0);
        check("R1 can_recv", int'(cons_can_recv), 0);
        check("R1 can_send", int'(prod_can_send), 1);

        mcycle(2, 8'h11, 0, 0, 0);
        mcycle(2, 8'h22, 1, 0, 1);
        mcycle(1, 0,     1, 1, 2);   // R3 bubble
        mcycle(0, 0,     0, 1, 0);   // R3 pass; bubble not offered
        mcycle(2, 8'h33, 0, 0, 1);
        // R7: credit returned in the cycle above 8'h33's predecessor arrives late
        mcycle(2, 8'h44, 1, 0, 0);
        mcycle(2, 8'h55, 0, 1, 2);   // R9: 8'h44 left unpopped
        mcycle(0, 0,     1, 2, 0);   // offers 8'h55 only
        for (int i = 0; i < 24; i++) begin
            mcycle((i % 4 == 3) ? 0 : ((i % 5 == 4) ? 1 : 2), 8'h60 + i,
                   1, (i % 2 == 1) ? 2 : 0, i % 3);
        end
        for (int i = 0; i < 4; i++) mcycle(0, 0, 1, 3, 1);
        check("R7 credits after drain", int'(prod_credits), r_cred);

        // zero-latency instance: R6 and R7 with CRED_LAT=0
        check("R1 zero inst credits", int'(q_credits), 1);
        q_enq = 1; q_valid = 1; q_din = 8'h5A;
        #1;
        check("R6 can_recv same clock", int'(q_can_recv), 1);
        check("R6 data same clock", int'(q_dout), 8'h5A);
        @(negedge clk);
        q_enq = 0; q_valid = 0;
        check("R2 zero inst credit spent", int'(q_credits), 0);
        check("R8 zero inst can_send closed", int'(q_can_send), 0);
        check("R6 message still offered", int'(q_can_recv), 1);
        q_pop = 1; q_done = 1; q_cred = 1'b1;
        @(negedge clk);
        q_pop = 0; q_done = 0; q_cred = '0;
        check("R7 credit back next model cycle", int'(q_credits), 1);
        check("R4 zero inst advanced", int'(q_cyc), 1);
        check("R6 nothing offered", int'(q_can_recv), 0);
        check("R2 zero inst can_send", int'(q_can_send), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule